// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Flag

The block draws a sprite eight pixels wide and 1 to 15 rows tall into a framebuffer with one bit per pixel, kept in on-chip storage. A start command supplies an X coordinate, a Y coordinate, a row count and the address of the first sprite byte. The block then fetches one byte per row from a byte-wide sprite memory and combines each of the eight bits with the framebuffer pixel beneath it by exclusive-or. Pixels that fall off the right or bottom edge wrap to the opposite edge.

While drawing, the block records whether any pixel that was lit has been turned dark. Software commonly uses this as a hit test between sprites. A one-cycle done pulse ends each command. The framebuffer can be read one pixel at a time through a peek port. Reset blanks the whole framebuffer.

Top module: `sprite_xor_blitter`

## Requirements
- R1: After reset, busy, done, collision and reject are 0 and every framebuffer pixel reads 0.
- R2: Row r (counting from 0) of the sprite is the byte read from sprite address base_addr + r, modulo 2^AW. Bit 7 of that byte is the pixel at column offset 0, and bit 0 is the pixel at offset 7.
- R3: Each sprite pixel sets framebuffer pixel = old pixel XOR sprite bit. A sprite bit of 0 leaves the pixel unchanged.
- R4: The target pixel of row r, column c is x = (x_in + c) mod 64 and y = (y_in + r) mod 32. The screen defaults to 64x32 and is stored at index y*64 + x.
- R5: collision goes to 0 in the cycle after a start is accepted. It becomes 1 only if some pixel that was 1 is turned to 0, and it keeps its value from done until the next accepted start.
- R6: A start with height 0 while idle is not executed. reject is 1 for exactly the next cycle, busy stays 0, and the framebuffer and collision are unchanged.
- R7: start is ignored while busy is 1. The running command completes with its own parameters and timing.
- R8: busy is 1 from the cycle after an accepted start through the done cycle. For a height of h, done is high for exactly one cycle, 10*h+1 cycles after the accepting clock edge.
- R9: A command of height h asserts spr_rd exactly h times. spr_rd is never high in two consecutive cycles, and read data is taken one cycle after spr_rd.
- R10: peek_pix shows the framebuffer pixel at (peek_x, peek_y) one clock after those inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken only while idle |
| x_in | input | CW (8) | X coordinate of the sprite's left column |
| y_in | input | CW (8) | Y coordinate of the sprite's top row |
| height | input | HW (4) | Number of rows; 0 is rejected |
| base_addr | input | AW (12) | Sprite memory address of the first row byte |
| spr_rd | output | 1 | Sprite memory read strobe |
| spr_addr | output | AW (12) | Sprite memory read address |
| spr_data | input | 8 | Sprite byte, valid the cycle after spr_rd |
| peek_x | input | XBITS (6) | Column to inspect |
| peek_y | input | YBITS (5) | Row to inspect |
| peek_pix | output | 1 | Registered pixel value at the peek position |
| busy | output | 1 | Command in progress, done cycle included |
| done | output | 1 | One-cycle end-of-command pulse |
| collision | output | 1 | A lit pixel was turned dark by the last command |
| reject | output | 1 | One-cycle pulse for a zero-height start |

## Verification
The assertions check the following on every cycle:
- done and reject are single-cycle pulses.
- A reject never coincides with busy.
- An accepted start clears collision and raises busy.
- collision never drops during a command and holds while idle.
- Sprite reads are isolated single strobes issued only while busy.

Only the bench scenarios can show the remaining behaviour:
- pixel-exact XOR results with wrap at both edges;
- the MSB-first bit order and the row address sequence;
- the exact done latency;
- that a start issued mid-command leaves the framebuffer unaffected.

The bench shows these by comparing the whole framebuffer through the peek port against a reference model.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_DRAW  = 3'd3,
        ST_DONE  = 3'd4
    } blit_st_e;

    localparam int SPRITE_W = 8;

endpackage

// File: rtl/blit_fb.sv
module blit_fb #(
    parameter int XBITS = 6,
    parameter int YBITS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [XBITS+YBITS-1:0] waddr,
    input  logic                   wdata,
    output logic                   old_pix,
    input  logic [XBITS+YBITS-1:0] peek_addr,
    output logic                   peek_pix
);
    localparam int NPIX = 1 << (XBITS + YBITS);

    logic [NPIX-1:0] pix_q;
    logic            peek_q;

    // Read side of the read-modify-write, same cycle as the write address
    assign old_pix  = pix_q[waddr];
    assign peek_pix = peek_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q  <= '0;
            peek_q <= 1'b0;
        end else begin
            if (we) begin
                pix_q[waddr] <= wdata;
            end
            peek_q <= pix_q[peek_addr];
        end
    end

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
#(
    parameter int XBITS = 6,
    parameter int YBITS = 5,
    parameter int AW    = 12,
    parameter int CW    = 8,
    parameter int HW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CW-1:0]          x_in,
    input  logic [CW-1:0]          y_in,
    input  logic [HW-1:0]          height,
    input  logic [AW-1:0]          base_addr,
    output logic                   spr_rd,
    output logic [AW-1:0]          spr_addr,
    input  logic [7:0]             spr_data,
    output logic                   pix_we,
    output logic [XBITS+YBITS-1:0] pix_addr,
    output logic                   pix_new,
    input  logic                   pix_old,
    output logic                   busy,
    output logic                   done,
    output logic                   collision,
    output logic                   reject
);
    localparam int CBITS = $clog2(SPRITE_W);
    localparam logic [CBITS-1:0] LAST_COL = CBITS'(SPRITE_W - 1);

    typedef struct packed {
        blit_st_e         st;
        logic [XBITS-1:0] xb;
        logic [YBITS-1:0] yb;
        logic [HW-1:0]    hgt;
        logic [AW-1:0]    base;
        logic [HW-1:0]    row;
        logic [CBITS-1:0] col;
        logic [7:0]       sbyte;
        logic             coll;
        logic             rej;
    } seq_s;

    seq_s s_d, s_q;

    logic [XBITS-1:0] x_cur;
    logic [YBITS-1:0] y_cur;
    logic             last_row;
    logic             unused_hi;

    // Only the low bits of the coordinates matter after wrap
    assign unused_hi = ^{x_in, y_in};

    always_comb begin
        s_d      = s_q;
        s_d.rej  = 1'b0;
        spr_rd   = 1'b0;
        pix_we   = 1'b0;
        x_cur    = s_q.xb + XBITS'(s_q.col);
        y_cur    = s_q.yb + YBITS'(s_q.row);
        pix_addr = {y_cur, x_cur};
        pix_new  = pix_old ^ s_q.sbyte[7];
        spr_addr = s_q.base + AW'(s_q.row);
        last_row = (s_q.row == (s_q.hgt - HW'(1)));

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (height == '0) begin
                        s_d.rej = 1'b1;
                    end else begin
                        s_d.xb   = x_in[XBITS-1:0];
                        s_d.yb   = y_in[YBITS-1:0];
                        s_d.hgt  = height;
                        s_d.base = base_addr;
                        s_d.row  = '0;
                        s_d.col  = '0;
                        s_d.coll = 1'b0;
                        s_d.st   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                spr_rd = 1'b1;
                s_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                s_d.sbyte = spr_data;
                s_d.col   = '0;
                s_d.st    = ST_DRAW;
            end
            ST_DRAW: begin
                pix_we = 1'b1;
                if (s_q.sbyte[7] && pix_old) begin
                    s_d.coll = 1'b1;
                end
                s_d.sbyte = {s_q.sbyte[6:0], 1'b0};
                s_d.col   = s_q.col + CBITS'(1);
                if (s_q.col == LAST_COL) begin
                    if (last_row) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.row = s_q.row + HW'(1);
                        s_d.st  = ST_FETCH;
                    end
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = (s_q.st == ST_DONE);
    assign collision = s_q.coll;
    assign reject    = s_q.rej;

endmodule

// File: rtl/sprite_xor_blitter.sv
module sprite_xor_blitter #(
    parameter int XBITS = 6,
    parameter int YBITS = 5,
    parameter int AW    = 12,
    parameter int CW    = 8,
    parameter int HW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    x_in,
    input  logic [CW-1:0]    y_in,
    input  logic [HW-1:0]    height,
    input  logic [AW-1:0]    base_addr,
    output logic             spr_rd,
    output logic [AW-1:0]    spr_addr,
    input  logic [7:0]       spr_data,
    input  logic [XBITS-1:0] peek_x,
    input  logic [YBITS-1:0] peek_y,
    output logic             peek_pix,
    output logic             busy,
    output logic             done,
    output logic             collision,
    output logic             reject
);
    localparam int PAW = XBITS + YBITS;

    logic           pix_we;
    logic [PAW-1:0] pix_addr;
    logic           pix_new;
    logic           pix_old;

    blit_seq #(
        .XBITS(XBITS), .YBITS(YBITS), .AW(AW), .CW(CW), .HW(HW)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .x_in      (x_in),
        .y_in      (y_in),
        .height    (height),
        .base_addr (base_addr),
        .spr_rd    (spr_rd),
        .spr_addr  (spr_addr),
        .spr_data  (spr_data),
        .pix_we    (pix_we),
        .pix_addr  (pix_addr),
        .pix_new   (pix_new),
        .pix_old   (pix_old),
        .busy      (busy),
        .done      (done),
        .collision (collision),
        .reject    (reject)
    );

    blit_fb #(
        .XBITS(XBITS), .YBITS(YBITS)
    ) fb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pix_we),
        .waddr     (pix_addr),
        .wdata     (pix_new),
        .old_pix   (pix_old),
        .peek_addr ({peek_y, peek_x}),
        .peek_pix  (peek_pix)
    );

endmodule

// File: rtl/blit_chk.sv
module blit_chk #(
    parameter int HW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [HW-1:0] height,
    input logic          spr_rd,
    input logic          busy,
    input logic          done,
    input logic          collision,
    input logic          reject
);
    logic accept;
    assign accept = start && !busy && (height != '0);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R7
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy); // R6
    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject); // R6
    AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !collision); // R5
    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && collision) |=> collision); // R5
    AST_COLL_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> $stable(collision)); // R5
    AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        spr_rd |-> busy); // R9
    AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        spr_rd |=> !spr_rd); // R9

endmodule

bind sprite_xor_blitter blit_chk #(.HW(HW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .height    (height),
    .spr_rd    (spr_rd),
    .busy      (busy),
    .done      (done),
    .collision (collision),
    .reject    (reject)
);

// File: tb/sprite_xor_blitter_tb_top.sv
module sprite_xor_blitter_tb_top;
    localparam int XBITS = 6;
    localparam int YBITS = 5;
    localparam int AW    = 12;
    localparam int CW    = 8;
    localparam int HW    = 4;
    localparam int SW    = 1 << XBITS;
    localparam int SH    = 1 << YBITS;
    localparam int MSZ   = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CW-1:0]    x_in = '0;
    logic [CW-1:0]    y_in = '0;
    logic [HW-1:0]    height = '0;
    logic [AW-1:0]    base_addr = '0;
    logic             spr_rd;
    logic [AW-1:0]    spr_addr;
    logic [7:0]       spr_data = '0;
    logic [XBITS-1:0] peek_x = '0;
    logic [YBITS-1:0] peek_y = '0;
    logic             peek_pix;
    logic             busy, done, collision, reject;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int rd_cnt  = 0;
    int addr_err = 0;
    int exp_base = 0;

    bit       model [SW*SH];
    bit [7:0] smem  [MSZ];

    always #2 clk = ~clk; // 250 MHz

    sprite_xor_blitter #(
        .XBITS(XBITS), .YBITS(YBITS), .AW(AW), .CW(CW), .HW(HW)
    ) dut_i (.*);

    // Sprite memory: registered read, one cycle latency; checks the row address sequence
    always @(posedge clk) begin
        if (spr_rd) begin
            spr_data <= smem[spr_addr];
            if (int'(spr_addr) != ((exp_base + rd_cnt) % MSZ)) addr_err++;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference drawing: returns expected collision
    function automatic bit model_draw(input int x, input int y, input int h, input int base);
        bit hit = 0;
        for (int r = 0; r < h; r++) begin
            bit [7:0] b = smem[(base + r) % MSZ];
            for (int c = 0; c < 8; c++) begin
                if (b[7-c]) begin
                    int idx = ((y + r) % SH) * SW + ((x + c) % SW);
                    if (model[idx]) hit = 1;
                    model[idx] = ~model[idx];
                end
            end
        end
        return hit;
    endfunction

    // Full framebuffer comparison through the peek port (R10 path)
    task automatic compare_fb(input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int yy = 0; yy < SH; yy++) begin
            for (int xx = 0; xx < SW; xx++) begin
                peek_x = XBITS'(xx);
                peek_y = YBITS'(yy);
                @(negedge clk);
                if (peek_pix != model[yy*SW + xx]) begin
                    if (bad == 0) begin
                        first_act = yy*SW + xx + (peek_pix ? 10000 : 0);
                        first_exp = yy*SW + xx + (model[yy*SW+xx] ? 10000 : 0);
                    end
                    bad++;
                end
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic blit(input int x, input int y, input int h, input int base,
                        input bit poke_busy, input bit full_cmp);
        int n = 0;
        bit exp_coll;
        exp_base = base;
        rd_cnt   = 0;
        addr_err = 0;
        x_in = CW'(x); y_in = CW'(y); height = HW'(h); base_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_coll = model_draw(x, y, h, base);
        chk(busy == 1'b1 && collision == 1'b0, "R5/R8 accept", {busy, collision}, 2);
        n = 1;
        while (!done && n < 400) begin
            if (poke_busy && n == 5) begin
                x_in = 8'h11; y_in = 8'h07; height = 4'd9; base_addr = 12'h3A0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n == 10*h + 1, poke_busy ? "R7 latency" : "R8 latency", n, 10*h + 1);
        chk(collision == exp_coll, "R5 collision", collision, exp_coll);
        @(negedge clk);
        chk(!done && !busy, "R8 done pulse", {done, busy}, 0);
        chk(rd_cnt == h && addr_err == 0, "R9/R2 reads", rd_cnt*100 + addr_err, h*100);
        if (full_cmp) compare_fb(poke_busy ? "R7 framebuffer" : "R3/R4 framebuffer");
    endtask

    initial begin
        int unsigned seed = $urandom(32'd20240611);
        bit coll_before;
        for (int i = 0; i < MSZ; i++) smem[i] = 8'($urandom);
        for (int i = 0; i < SW*SH; i++) model[i] = 1'b0;
        smem[12'h100] = 8'b1000_0001;  // single-bit order probe
        smem[12'h101] = 8'b0100_0000;
        smem[12'hFFF] = 8'hFF;         // address wrap probe
        smem[12'h000] = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !collision && !reject, "R1 reset outputs",
            {busy, done, collision, reject}, 0);
        compare_fb("R1 reset framebuffer");

        // R2 bit order: MSB leftmost
        blit(10, 4, 2, 12'h100, 0, 1);
        peek_x = 6'd10; peek_y = 5'd4; @(negedge clk);
        chk(peek_pix == 1'b1, "R2 msb at x", peek_pix, 1);
        peek_x = 6'd17; peek_y = 5'd4; @(negedge clk);
        chk(peek_pix == 1'b1, "R2 lsb at x+7", peek_pix, 1);
        peek_x = 6'd11; peek_y = 5'd5; @(negedge clk);
        chk(peek_pix == 1'b1, "R10 peek row 2", peek_pix, 1);

        // R4 wrap at both edges, with sprite address wrap (R2)
        blit(60, 30, 5, 12'hFFE, 0, 1);
        blit(255, 255, 15, 12'h200, 0, 1);

        // R5 redraw same sprite: collision and erase
        blit(20, 8, 6, 12'h300, 0, 1);
        blit(20, 8, 6, 12'h300, 0, 1);
        chk(collision == 1'b1, "R5 redraw collides", collision, 1);

        // R6 zero height rejected
        coll_before = collision;
        height = '0; x_in = 8'd3; y_in = 8'd3; base_addr = 12'h100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(reject && !busy, "R6 reject pulse", {reject, busy}, 2);
        @(negedge clk);
        chk(!reject && !busy && collision == coll_before, "R6 no effect",
            {reject, busy, collision}, {1'b0, 1'b0, coll_before});
        compare_fb("R6 framebuffer untouched");

        // R7 start while busy ignored
        blit(33, 12, 7, 12'h050, 1, 1);

        // Random commands
        for (int k = 0; k < 20; k++) begin
            int h = 1 + ($urandom % 15);
            blit($urandom % 256, $urandom % 256, h, $urandom % MSZ, ($urandom % 4) == 0,
                 (k % 4) == 3);
        end
        compare_fb("R3 final framebuffer");

        summary();
        $finish;
    end

endmodule